// File: doc/BRIEF.md
# Priority Interrupt Controller Core

This block arbitrates 128 interrupt source numbers for one processor. Source numbers 0 to 7 are software flags, set and cleared by register writes. Numbers 8 to 23 are reserved and never request. Numbers 24 to 127 follow the level of the matching peripheral input line. Each source carries a 4-bit priority, and a source whose priority is zero never takes part. A combinational arbiter picks the highest-priority pending source and turns its number into a 9-bit vector. The request line to the processor rises only when that priority is strictly above the current priority.

An acknowledge saves the running current priority on a 15-entry priority stack and raises the current priority to that of the acknowledged source. In software vector mode the handler acknowledges by reading the acknowledge register, which also returns the vector. In hardware vector mode the processor takes the vector from a port and pulses an acknowledge strobe. A write to the end-of-interrupt register pops the stack back into the current priority, so nested handlers unwind in order.

All registers are 32 bits wide and sit at word addresses on a simple single-cycle slave port. Read data is combinational from the address while the read enable is high. Writes take effect at the clock edge.

Top module: `pic_core`

## Requirements
- R1: Input lines irq_i[23:0] have no effect. Sources 8 to 23 never request. Sources 24 to 127 are pending while irq_i of the same index is high and their priority is non-zero.
- R2: The priority registers start at address 0x10. Source k uses the register at 0x10 + k/8, bits [4*(k%8)+3 : 4*(k%8)]. These registers read back what was written and reset to 0. A source with priority 0 never requests.
- R3: irq_req_o is high exactly when a source is pending and the highest pending priority is strictly greater than the current priority.
- R4: When several pending sources share the top priority, the lowest source number wins. vector_o is the winning source number, zero-extended to 9 bits, or 0 when no source is pending. Reading the acknowledge register (0x02) returns that same value in bits [8:0].
- R5: Bit 0 of the configuration register (0x00) selects hardware vector mode. It resets to 0, and hv_en_o follows it one cycle after the write.
- R6: In software vector mode, a read of 0x02 while irq_req_o is high is an acknowledge. ack_i has no effect in this mode. An acknowledge stores the old current priority on the stack and loads the winner's priority as the new current priority.
- R7: In hardware vector mode, a pulse on ack_i while irq_req_o is high is an acknowledge with the same effect. Reading 0x02 has no effect in this mode.
- R8: A write to 0x03 (end of interrupt) pops the stack top into the current priority. When the stack is empty, the current priority is unchanged. An acknowledge in the same cycle takes precedence over the pop.
- R9: The stack holds 15 entries. A push while it is full is dropped, but the current priority still takes the winner's priority.
- R10: The current priority register (0x01, bits [3:0]) can be read and written, and resets to 0.
- R11: A write to 0x04 sets software flags from bits [7:0] and clears them from bits [23:16]. When a bit is both set and cleared in one write, set wins. A read of 0x04 returns the flags in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 128 | Peripheral request levels, indexed by source number |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while rd_en_i is high |
| ack_i | input | 1 | Acknowledge strobe from the processor, used in hardware vector mode |
| irq_req_o | output | 1 | Interrupt request to the processor |
| hv_en_o | output | 1 | Hardware vector mode enable to the processor |
| vector_o | output | 9 | Vector of the current winner |

## Verification
The hardest state to reach from the ports is a full priority stack followed by one more acknowledge. Reaching it needs fifteen nested acknowledges, and strict priority nesting alone runs out of levels before that. The stimulus therefore writes the current priority register before each acknowledge of a priority-15 source. This stores the values 0 to 14, forces a sixteenth acknowledge, and then checks that the pops unwind 14 down to 0 without the dropped value appearing. Seeded random sequences then mix line changes, priority rewrites, flag writes, both acknowledge paths and end-of-interrupt writes against a reference model.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_CFG  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CUR  = 8'h01;
  localparam logic [ADDR_W-1:0] A_ACK  = 8'h02;
  localparam logic [ADDR_W-1:0] A_EOI  = 8'h03;
  localparam logic [ADDR_W-1:0] A_SWF  = 8'h04;
  localparam logic [ADDR_W-1:0] A_PRIO = 8'h10;
endpackage

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int unsigned N  = 128,
  parameter int unsigned W  = 4,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]        pend_i,
  input  logic [N-1:0][W-1:0] prio_i,
  output logic [IW-1:0]       idx_o,
  output logic [W-1:0]        prio_o,
  output logic                vld_o
);
  // descending scan with >= leaves the lowest index on a tie
  always_comb begin
    idx_o  = '0;
    prio_o = '0;
    vld_o  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i] && prio_i[i] >= prio_o) begin
        idx_o  = IW'(i);
        prio_o = prio_i[i];
        vld_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic_lifo.sv
module pic_lifo #(
  parameter int unsigned DEPTH = 15,
  parameter int unsigned W     = 4,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          full, empty;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (push_i && !full) cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full) mem_q[cnt_q] <= din_i;
  end

  assign dout_o = empty ? '0 : mem_q[cnt_q - 1'b1];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter int unsigned N_SRC      = 128,
  parameter int unsigned N_SW       = 8,
  parameter int unsigned N_RSV      = 16,
  parameter int unsigned PRIO_W     = 4,
  parameter int unsigned VEC_W      = 9,
  parameter int unsigned LIFO_DEPTH = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ack_i,
  output logic              irq_req_o,
  output logic              hv_en_o,
  output logic [VEC_W-1:0]  vector_o
);
  localparam int unsigned IDX_W    = $clog2(N_SRC);
  localparam int unsigned PER_REG  = DATA_W / PRIO_W;
  localparam int unsigned N_PREG   = N_SRC / PER_REG;
  localparam int unsigned PA_W     = (N_PREG > 1) ? $clog2(N_PREG) : 1;
  localparam int unsigned FIRST_HW = N_SW + N_RSV;
  localparam int unsigned CNT_W    = $clog2(LIFO_DEPTH + 1);
  localparam logic [ADDR_W-1:0] PRIO_END = A_PRIO + ADDR_W'(N_PREG);

  logic                          hv_q;
  logic [PRIO_W-1:0]             cur_q;
  logic [N_SW-1:0]               sw_q;
  logic [N_SRC-1:0][PRIO_W-1:0]  prio_q;
  logic [N_SRC-1:0]              pend;
  logic [IDX_W-1:0]              win_idx;
  logic [PRIO_W-1:0]             win_prio;
  logic                          win_vld;
  logic                          ack_evt, eoi_evt;
  logic [PRIO_W-1:0]             lifo_top;
  logic [CNT_W-1:0]              lifo_cnt;
  logic [PA_W-1:0]               preg_idx;
  logic [DATA_W-1:0]             prio_word;
  logic                          in_prio;
  logic                          unused_irq;

  assign unused_irq = ^irq_i[FIRST_HW-1:0];

  // priority select bank and source qualification
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    localparam int unsigned RI = g / PER_REG;
    localparam int unsigned SI = g % PER_REG;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[g] <= '0;
      else if (wr_en_i && addr_i == A_PRIO + ADDR_W'(RI))
        prio_q[g] <= wdata_i[SI*PRIO_W +: PRIO_W];
    end
    if (g < N_SW) begin : g_sw
      assign pend[g] = sw_q[g] && (prio_q[g] != '0);
    end else if (g < FIRST_HW) begin : g_rsv
      assign pend[g] = 1'b0;
    end else begin : g_hw
      assign pend[g] = irq_i[g] && (prio_q[g] != '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv_q <= 1'b0;
      sw_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_CFG) hv_q <= wdata_i[0];
      if (addr_i == A_SWF) sw_q <= (sw_q & ~wdata_i[16 +: N_SW]) | wdata_i[0 +: N_SW];
    end
  end

  pic_arb #(.N(N_SRC), .W(PRIO_W), .IW(IDX_W)) u_arb (
    .pend_i (pend),
    .prio_i (prio_q),
    .idx_o  (win_idx),
    .prio_o (win_prio),
    .vld_o  (win_vld)
  );

  assign irq_req_o = win_vld && (win_prio > cur_q);
  assign vector_o  = VEC_W'(win_idx);
  assign hv_en_o   = hv_q;

  assign ack_evt = irq_req_o && (hv_q ? ack_i : (rd_en_i && addr_i == A_ACK));
  assign eoi_evt = wr_en_i && (addr_i == A_EOI);

  pic_lifo #(.DEPTH(LIFO_DEPTH), .W(PRIO_W), .CW(CNT_W)) u_lifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (ack_evt),
    .pop_i  (eoi_evt && !ack_evt),
    .din_i  (cur_q),
    .dout_o (lifo_top),
    .cnt_o  (lifo_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else if (ack_evt) cur_q <= win_prio;
    else if (eoi_evt && lifo_cnt != '0) cur_q <= lifo_top;
    else if (wr_en_i && addr_i == A_CUR) cur_q <= wdata_i[PRIO_W-1:0];
  end

  // read path
  assign in_prio  = (addr_i >= A_PRIO) && (addr_i < PRIO_END);
  assign preg_idx = PA_W'(addr_i - A_PRIO);

  always_comb begin
    prio_word = '0;
    for (int j = 0; j < PER_REG; j++)
      prio_word[j*PRIO_W +: PRIO_W] = prio_q[int'(preg_idx) * PER_REG + j];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (in_prio) rdata_o = prio_word;
      else begin
        case (addr_i)
          A_CFG: rdata_o[0] = hv_q;
          A_CUR: rdata_o[PRIO_W-1:0] = cur_q;
          A_ACK: rdata_o[VEC_W-1:0] = vector_o;
          A_SWF: rdata_o[N_SW-1:0] = sw_q;
          default: rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_core_sva.sv
module pic_core_sva
  import pic_pkg::*;
#(
  parameter int unsigned N_SW   = 8,
  parameter int unsigned N_RSV  = 16,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned VEC_W  = 9,
  parameter int unsigned DEPTH  = 15,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_req_o,
  input logic [VEC_W-1:0]  vector_o,
  input logic              hv_en_o,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              cfg_bit,
  input logic              ack_evt,
  input logic              eoi_evt,
  input logic [PRIO_W-1:0] cur_q,
  input logic [PRIO_W-1:0] win_prio,
  input logic [CNT_W-1:0]  lifo_cnt
);
  p_no_rsv_vec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (vector_o < VEC_W'(N_SW) || vector_o >= VEC_W'(N_SW + N_RSV)));

  p_hv_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CFG) |=> (hv_en_o == $past(cfg_bit)));

  p_ack_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_evt |=> (cur_q == $past(win_prio)));

  p_eoi_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_evt && !ack_evt && lifo_cnt == '0) |=> $stable(cur_q));

  p_lifo_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lifo_cnt <= CNT_W'(DEPTH));

  p_full_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_evt && lifo_cnt == CNT_W'(DEPTH)) |=> (lifo_cnt == CNT_W'(DEPTH)));
endmodule

bind pic_core pic_core_sva #(
  .N_SW(N_SW), .N_RSV(N_RSV), .PRIO_W(PRIO_W), .VEC_W(VEC_W),
  .DEPTH(LIFO_DEPTH), .CNT_W(CNT_W)
) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_req_o (irq_req_o),
  .vector_o  (vector_o),
  .hv_en_o   (hv_en_o),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .cfg_bit   (wdata_i[0]),
  .ack_evt   (ack_evt),
  .eoi_evt   (eoi_evt),
  .cur_q     (cur_q),
  .win_prio  (win_prio),
  .lifo_cnt  (lifo_cnt)
);

// File: tb/pic_core_test.sv
`timescale 1ns/1ps
module pic_core_test;
  import pic_pkg::*;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] irq_i = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0, rdata;
  logic         irq_req, hv_en;
  logic [8:0]   vector;

  int n_cmp = 0, n_err = 0;

  bit [3:0] prio_m [128];
  bit [7:0] flg_m;
  bit [3:0] cur_m;
  bit [3:0] stk_m [15];
  int       cnt_m;
  bit       hv_m;

  always #10 clk = ~clk;

  pic_core uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq_i), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ack_i(ack),
    .irq_req_o(irq_req), .hv_en_o(hv_en), .vector_o(vector)
  );

  function automatic int m_win();
    int best = -1;
    bit [3:0] bp = 0;
    for (int i = 0; i < 128; i++) begin
      bit p;
      p = (i < 8) ? flg_m[i] : (i >= 24) ? irq_i[i] : 1'b0;
      if (p && prio_m[i] > bp) begin bp = prio_m[i]; best = i; end
    end
    return best;
  endfunction

  function automatic bit m_req();
    int w = m_win();
    return (w >= 0) && (prio_m[w] > cur_m);
  endfunction

  function automatic int m_vec();
    int w = m_win();
    return (w < 0) ? 0 : w;
  endfunction

  task automatic m_ack();
    int w = m_win();
    if (cnt_m < 15) begin stk_m[cnt_m] = cur_m; cnt_m++; end
    cur_m = prio_m[w];
  endtask

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      A_CFG: hv_m = d[0];
      A_CUR: cur_m = d[3:0];
      A_EOI: if (cnt_m > 0) begin cnt_m--; cur_m = stk_m[cnt_m]; end
      A_SWF: flg_m = (flg_m & ~d[23:16]) | d[7:0];
      default:
        if (a >= 8'h10 && a < 8'h20)
          for (int j = 0; j < 8; j++) prio_m[(a - 8'h10) * 8 + j] = d[j*4 +: 4];
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bit fire;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    fire = (a == A_ACK) && !hv_m && m_req();
    @(negedge clk);
    rd_en = 1'b0;
    if (fire) m_ack();
  endtask

  task automatic hw_ack();
    bit fire;
    @(negedge clk);
    ack = 1'b1;
    fire = hv_m && m_req();
    @(negedge clk);
    ack = 1'b0;
    if (fire) m_ack();
  endtask

  task automatic set_prio(int src, bit [3:0] p);
    logic [31:0] w;
    int base = (src / 8) * 8;
    prio_m[src] = p;
    for (int j = 0; j < 8; j++) w[j*4 +: 4] = prio_m[base + j];
    wr(8'(8'h10 + src / 8), w);
  endtask

  task automatic set_irq(int src, bit v);
    @(negedge clk);
    irq_i[src] = v;
  endtask

  task automatic check_all();
    #1;
    chk("R3 irq_req", irq_req, m_req());
    chk("R4 vector", vector, m_vec());
    chk("R5 hv_en", hv_en, hv_m);
  endtask

  task automatic check_cur(string tag);
    logic [31:0] d;
    rd(A_CUR, d);
    chk(tag, d[3:0], cur_m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    check_all();
    check_cur("R10 cur reset");
    rd(A_CFG, d); chk("R5 cfg reset", d, 0);
    rd(A_SWF, d); chk("R11 flags reset", d, 0);

    // R2 priority bank and basic request
    set_prio(40, 5); set_irq(40, 1); check_all();
    rd(8'h15, d); chk("R2 prio readback", d, 5);
    set_irq(41, 1); check_all();
    chk("R2 zero prio no request", vector, 40);

    // R4 ties and ordering
    set_prio(30, 5); set_irq(30, 1); check_all();
    chk("R4 tie lowest", vector, 30);
    set_prio(100, 7); set_irq(100, 1); check_all();
    rd(A_ACK, d);
    cur_m = cur_m; // no change expected: cur was 0, req high -> acked
    chk("R4 ack data", d[8:0], 100);
    check_cur("R6 sw ack loads prio");
    wr(A_EOI, 0); check_cur("R8 pop restores");

    // R1 reserved and unflagged sources
    set_prio(10, 15); set_prio(3, 15); set_irq(10, 1); set_irq(3, 1); check_all();
    chk("R1 reserved ignored", vector, 100);

    // R11 software flags
    wr(A_SWF, 32'h0000_0008); check_all();
    chk("R11 flag set", vector, 3);
    wr(A_SWF, 32'h0008_0008); rd(A_SWF, d); chk("R11 set wins", d, 8);
    wr(A_SWF, 32'h0008_0000); rd(A_SWF, d); chk("R11 clear", d, 0);
    check_all();

    // R3 strict threshold
    wr(A_CUR, 7); check_all(); chk("R3 equal blocks", irq_req, 0);
    wr(A_CUR, 6); check_all(); chk("R3 above raises", irq_req, 1);

    // R6 ack_i ignored in software mode, spurious ack ignored
    wr(A_CUR, 0); hw_ack(); check_cur("R6 ack_i ignored sw");
    rd(A_ACK, d); check_cur("R6 sw ack");
    rd(A_ACK, d); check_cur("R6 no req no ack");
    check_all();

    // R8 pops, empty pop
    wr(A_EOI, 0); check_cur("R8 pop");
    wr(A_CUR, 9); wr(A_EOI, 0); check_cur("R8 empty pop keeps");
    chk("R8 empty pop value", cur_m, 9);

    // R7 hardware mode
    wr(A_CUR, 0); wr(A_CFG, 1); check_all();
    rd(A_ACK, d); check_cur("R7 read no ack hw");
    hw_ack(); check_cur("R7 hw ack");
    chk("R7 hw ack value", cur_m, 7);
    wr(A_EOI, 0); check_cur("R7 pop after hw ack");
    wr(A_CFG, 0); check_all();

    // R9 full stack
    irq_i = '0; set_prio(50, 15); set_irq(50, 1);
    for (int i = 0; i < 15; i++) begin wr(A_CUR, 32'(i)); rd(A_ACK, d); end
    wr(A_CUR, 7); rd(A_ACK, d); check_cur("R9 cur after full push");
    for (int i = 14; i >= 0; i--) begin
      wr(A_EOI, 0); rd(A_CUR, d); chk("R9 unwind order", d[3:0], i);
    end
    wr(A_EOI, 0); check_cur("R9 empty after unwind");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0, 1: begin @(negedge clk); irq_i = {$urandom, $urandom, $urandom, $urandom}; end
        2, 3: set_prio($urandom_range(0, 127), 4'($urandom));
        4: wr(A_SWF, $urandom & 32'h00FF_00FF);
        5: wr(A_CUR, 32'($urandom_range(0, 15)));
        6: rd(A_ACK, d);
        7: hw_ack();
        8: wr(A_EOI, 0);
        default: wr(A_CFG, 32'($urandom_range(0, 1)));
      endcase
      check_all();
      if (it % 8 == 0) check_cur("R6 R7 R8 random cur");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule